// File: doc/BRIEF.md
# Three-Key Sequence Door Lock

This block is a clocked Moore state machine that watches a keypad and releases a door when a fixed three-key code is entered in order. Each key press arrives as a one-cycle pulse on a valid flag together with a key identity, already synchronous to the clock. The code, as shipped, is key 'B', then key 'A', then key 'B'. When the last key of a correct attempt is taken, the block raises an unlock pulse for exactly one cycle and then goes back to waiting.

A wrong key does not end an attempt early. The machine moves onto a separate bad path that still counts keys, so a 4-bit key count, meant for a display decoder, climbs 1, 2 in the same way whether the keys so far are right or wrong. Only after the third key does the outcome show: either the unlock pulse with the count at 3, or a silent return to a count of 0. Cycles with no key leave the attempt where it is, so the user may pause between keys for any length of time. Encodings of the state register that the machine never enters fall back to the waiting state on the next clock.

Top module: `seq_door_lock`

## Requirements
- R1: A key is taken only in a cycle with `key_valid` high; `key_id` 2'b10 is key 'A', 2'b01 is key 'B', and 2'b00 or 2'b11 with `key_valid` high is an "other" key that never matches the code. With `key_valid` low, `key_id` has no effect.
- R2: The keys 'B', 'A', 'B' taken in that order raise `unlock` in the cycle after the clock edge that takes the third key, for exactly one cycle.
- R3: A cycle with no key leaves `key_count` and `unlock` unchanged, so gaps of any length between keys are allowed.
- R4: `key_count` is 0 while waiting, 1 after the first key of an attempt, 2 after the second, and 3 only while `unlock` is high.
- R5: A wrong first key still gives a count of 1 and then 2 on the next key; the third key returns the count to 0 without `unlock`, whatever that key is.
- R6: A correct first key followed by a wrong second key gives counts 1 and 2; the third key returns the count to 0 without `unlock`.
- R7: Two correct keys followed by a wrong third key return the count to 0 without `unlock`.
- R8: The cycle after `unlock` the block is waiting again with a count of 0, whatever the inputs during the unlock cycle; a key in that cycle is dropped, and a new attempt may begin in the very next cycle.
- R9: With `rst_n` low, at once and without a clock, `unlock` is 0 and `key_count` is 0, and the next attempt starts from its first key.
- R10: The count bits above bit 1 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| key_valid | input | 1 | High for one cycle per key press |
| key_id | input | ID_W (2) | Identity of the pressed key |
| unlock | output | 1 | One-cycle release pulse |
| key_count | output | CNT_W (4) | Keys entered in the current attempt |

## Verification
The bench builds the lock with its default parameters: a 2-bit key identity, a 4-bit count and the code 'B', 'A', 'B'. With a 2-bit identity every possible key value, both matching and non-matching, can be driven, so each bad-path branch, including the two "other" codes, is reached from every step of an attempt. The 4-bit count leaves two upper bits that must stay at zero, which the bench watches on every cycle against its own model of the attempt.

// File: rtl/doorlock_pkg.sv
package doorlock_pkg;

  // State codes; values outside this set are never entered on purpose.
  typedef enum logic [2:0] {
    ST_WAIT  = 3'b000,
    ST_OK1   = 3'b010,
    ST_OK2   = 3'b100,
    ST_OPEN  = 3'b111,
    ST_BAD1  = 3'b001,
    ST_BAD2  = 3'b011
  } lock_state_e;

  localparam int unsigned CODE_LEN = 3;

  localparam logic [1:0] KEY_ID_A = 2'b10;
  localparam logic [1:0] KEY_ID_B = 2'b01;

endpackage

// File: rtl/doorlock_key_match.sv
module doorlock_key_match
  import doorlock_pkg::*;
#(
  parameter int unsigned ID_W = 2,
  parameter logic [CODE_LEN-1:0][ID_W-1:0] PASSCODE = '{ID_W'(1), ID_W'(2), ID_W'(1)}
) (
  input  logic                key_valid,
  input  logic [ID_W-1:0]     key_id,
  output logic                key_none,
  output logic [CODE_LEN-1:0] step_hit
);

  assign key_none = !key_valid;

  // One comparator for each position of the code.
  for (genvar g = 0; g < CODE_LEN; g++) begin : g_step
    assign step_hit[g] = key_valid && (key_id == PASSCODE[g]);
  end

endmodule

// File: rtl/doorlock_next.sv
module doorlock_next
  import doorlock_pkg::*;
(
  input  lock_state_e         cur_state,
  input  logic                key_none,
  input  logic [CODE_LEN-1:0] step_hit,
  output lock_state_e         nxt_state,
  output logic                step_en
);

  always_comb begin
    nxt_state = ST_WAIT;
    unique case (cur_state)
      ST_WAIT: nxt_state = key_none    ? ST_WAIT :
                           step_hit[0] ? ST_OK1  : ST_BAD1;
      ST_OK1:  nxt_state = key_none    ? ST_OK1  :
                           step_hit[1] ? ST_OK2  : ST_BAD2;
      ST_OK2:  nxt_state = key_none    ? ST_OK2  :
                           step_hit[2] ? ST_OPEN : ST_WAIT;
      ST_OPEN: nxt_state = ST_WAIT;
      ST_BAD1: nxt_state = key_none    ? ST_BAD1 : ST_BAD2;
      ST_BAD2: nxt_state = key_none    ? ST_BAD2 : ST_WAIT;
      default: nxt_state = ST_WAIT;
    endcase
  end

  // Register enable: a key moves the machine, the open state and any
  // stray encoding leave on their own.
  always_comb begin
    unique case (cur_state)
      ST_WAIT, ST_OK1, ST_OK2, ST_BAD1, ST_BAD2: step_en = !key_none;
      default:                                   step_en = 1'b1;
    endcase
  end

endmodule

// File: rtl/doorlock_out.sv
module doorlock_out
  import doorlock_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  lock_state_e      cur_state,
  output logic             unlock,
  output logic [CNT_W-1:0] key_count
);

  always_comb begin
    unlock    = 1'b0;
    key_count = '0;
    unique case (cur_state)
      ST_OK1, ST_BAD1: key_count = CNT_W'(1);
      ST_OK2, ST_BAD2: key_count = CNT_W'(2);
      ST_OPEN: begin
        key_count = CNT_W'(3);
        unlock    = 1'b1;
      end
      default: key_count = '0;
    endcase
  end

endmodule

// File: rtl/seq_door_lock.sv
module seq_door_lock
  import doorlock_pkg::*;
#(
  parameter int unsigned ID_W  = 2,
  parameter int unsigned CNT_W = 4,
  parameter logic [CODE_LEN-1:0][ID_W-1:0] PASSCODE = '{ID_W'(1), ID_W'(2), ID_W'(1)}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_valid,
  input  logic [ID_W-1:0]  key_id,
  output logic             unlock,
  output logic [CNT_W-1:0] key_count
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CODE_LEN);

  lock_state_e         state_q;
  lock_state_e         state_d;
  logic                step_en;
  logic                key_none;
  logic [CODE_LEN-1:0] step_hit;

  doorlock_key_match #(
    .ID_W     (ID_W),
    .PASSCODE (PASSCODE)
  ) u_match (
    .key_valid (key_valid),
    .key_id    (key_id),
    .key_none  (key_none),
    .step_hit  (step_hit)
  );

  doorlock_next u_next (
    .cur_state (state_q),
    .key_none  (key_none),
    .step_hit  (step_hit),
    .nxt_state (state_d),
    .step_en   (step_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
    end else if (step_en) begin
      state_q <= state_d;
    end
  end

  doorlock_out #(
    .CNT_W (CNT_W)
  ) u_out (
    .cur_state (state_q),
    .unlock    (unlock),
    .key_count (key_count)
  );

  // The release pulse lasts one cycle.
  assert_unlock_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> !unlock);

  // A pulse always follows a taken key.
  assert_unlock_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock) |-> $past(key_valid));

  // Idle cycles freeze the attempt.
  assert_hold_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_valid && !unlock) |=> ($stable(key_count) && !unlock));

  // Early keys advance the count by one, good or bad.
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !unlock && key_count < CNT_TWO) |=> (key_count == $past(key_count) + CNT_ONE));

  // The third key ends the attempt: open with the top count, or back to zero.
  assert_attempt_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_count == CNT_TWO) |=> (unlock ? (key_count == CNT_TOP) : (key_count == '0)));

  // After the pulse the machine waits again.
  assert_back_to_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (key_count == '0));

endmodule

// File: tb/seq_door_lock_tb.sv
`timescale 1ns/100ps
module seq_door_lock_tb;

  localparam int unsigned CNT_W = 4;
  localparam logic [1:0] K_A = 2'b10;
  localparam logic [1:0] K_B = 2'b01;
  localparam logic [1:0] CODE [3] = '{2'b01, 2'b10, 2'b01};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             key_valid;
  logic [1:0]       key_id;
  logic             unlock;
  logic [CNT_W-1:0] key_count;

  int n_checks = 0;
  int n_errors = 0;

  // Reference model of one attempt.
  int m_cnt  = 0;
  bit m_good = 1'b1;
  bit m_open = 1'b0;

  always #2.5 clk = ~clk;

  seq_door_lock u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_valid (key_valid),
    .key_id    (key_id),
    .unlock    (unlock),
    .key_count (key_count)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt  = 0;
    m_good = 1'b1;
    m_open = 1'b0;
  endtask

  task automatic model_step(input bit v, input logic [1:0] id);
    if (m_open) begin
      model_clear();
    end else if (v) begin
      if (id != CODE[m_cnt]) m_good = 1'b0;
      m_cnt++;
      if (m_cnt == 3) begin
        if (m_good) m_open = 1'b1;
        else model_clear();
      end
    end
  endtask

  // One clock: drive, take the edge, compare at the falling edge.
  task automatic tick(input bit v, input logic [1:0] id, input string tag);
    key_valid = v;
    key_id    = id;
    @(posedge clk);
    model_step(v, id);
    @(negedge clk);
    check(unlock == m_open, tag, "unlock", int'(unlock), int'(m_open));
    check(key_count == CNT_W'(m_cnt), tag, "key_count", int'(key_count), m_cnt);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; key_valid = 1'b0; key_id = 2'b00;
    #1;
    check(unlock == 1'b0, "R9", "unlock in reset", int'(unlock), 0);
    check(key_count == '0, "R9", "count in reset", int'(key_count), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    tick(1'b0, 2'b00, "R9");
  endtask

  task automatic t_good_with_gaps();
    tick(1'b1, K_B, "R4");
    repeat (3) tick(1'b0, 2'b11, "R3");
    tick(1'b1, K_A, "R4");
    repeat (5) tick(1'b0, K_B, "R1");
    tick(1'b1, K_B, "R2");
    check(unlock == 1'b1, "R2", "unlock after code", int'(unlock), 1);
    check(key_count == 4'd3, "R10", "full count width", int'(key_count), 3);
    tick(1'b0, 2'b00, "R2");
    check(unlock == 1'b0, "R2", "pulse width", int'(unlock), 0);
  endtask

  task automatic t_wrong_first();
    tick(1'b1, K_A, "R5");
    check(key_count == 4'd1, "R5", "count after bad first", int'(key_count), 1);
    tick(1'b0, 2'b00, "R3");
    tick(1'b1, K_A, "R5");
    check(key_count == 4'd2, "R5", "count after 2nd", int'(key_count), 2);
    tick(1'b1, K_B, "R5");
    check(key_count == 4'd0 && !unlock, "R5", "end of bad attempt", int'(key_count), 0);
  endtask

  task automatic t_wrong_second();
    tick(1'b1, K_B, "R6");
    tick(1'b1, K_B, "R6");
    check(key_count == 4'd2, "R6", "count after bad second", int'(key_count), 2);
    tick(1'b1, K_B, "R6");
    check(key_count == 4'd0 && !unlock, "R6", "end of bad attempt", int'(key_count), 0);
  endtask

  task automatic t_wrong_third();
    tick(1'b1, K_B, "R7");
    tick(1'b1, K_A, "R7");
    tick(1'b1, K_A, "R7");
    check(key_count == 4'd0 && !unlock, "R7", "wrong third key", int'(key_count), 0);
    tick(1'b1, K_B, "R7");
    tick(1'b1, K_A, "R7");
    tick(1'b1, 2'b11, "R7");
    check(key_count == 4'd0 && !unlock, "R7", "other third key", int'(key_count), 0);
  endtask

  task automatic t_other_codes();
    tick(1'b1, 2'b00, "R1");
    check(key_count == 4'd1, "R1", "code 00 counted", int'(key_count), 1);
    tick(1'b1, 2'b11, "R1");
    tick(1'b1, K_B, "R1");
    check(!unlock, "R1", "other codes never open", int'(unlock), 0);
    tick(1'b0, K_B, "R1");
    check(key_count == 4'd0, "R1", "invalid id ignored", int'(key_count), 0);
  endtask

  task automatic t_reentry();
    tick(1'b1, K_B, "R8");
    tick(1'b1, K_A, "R8");
    tick(1'b1, K_B, "R8");
    tick(1'b1, K_B, "R8");
    check(key_count == 4'd0 && !unlock, "R8", "key during pulse dropped", int'(key_count), 0);
    tick(1'b1, K_B, "R8");
    tick(1'b1, K_A, "R8");
    tick(1'b1, K_B, "R8");
    check(unlock == 1'b1, "R8", "immediate re-entry opens", int'(unlock), 1);
    tick(1'b0, 2'b00, "R8");
  endtask

  task automatic t_async_reset();
    tick(1'b1, K_B, "R9");
    tick(1'b1, K_A, "R9");
    rst_n = 1'b0;
    #1;
    check(key_count == '0, "R9", "async clear", int'(key_count), 0);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    tick(1'b1, K_B, "R9");
    check(key_count == 4'd1, "R9", "restart at first key", int'(key_count), 1);
    tick(1'b1, K_A, "R9");
    tick(1'b1, K_B, "R9");
    check(unlock == 1'b1, "R9", "open after reset", int'(unlock), 1);
    tick(1'b0, 2'b00, "R9");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL all: watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_good_with_gaps();
    t_wrong_first();
    t_wrong_second();
    t_wrong_third();
    t_other_codes();
    t_reentry();
    t_async_reset();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule